// File: doc/BRIEF.md
# Serial Converter Control-Byte Receiver

This block is the digital front end of a multichannel serial converter. A host drives chip select, a serial clock and a data-in line. The block watches these lines and skips any leading zero bits. It takes the first 1 as a start bit and gathers the rest of an 8-bit control byte. It then turns the select code and the mode bit into one-hot positive and negative input enables for the analog multiplexer.

Each accepted byte raises a one-cycle conversion request. A stub conversion engine models the busy time of the converter and holds the status strobe low while it runs. It then loads a result word, which the host clocks out on the data-out line. The line stays at zero until the first result exists.

The pins are sampled by a fast system clock through synchronizers. A parameter selects the 8-channel or the 4-channel variant.

Top module: `ctl_byte_rx`

## Requirements
- R1: After reset the status strobe is high, data-out is low, every enable and com_neg_o are low, and neither pulse output is active.
- R2: While chip select is low, one data-in bit is taken on each rising serial-clock edge. Serial-clock edges while chip select is high capture nothing.
- R3: After chip select falls, any number of 0 bits are discarded. The first 1 is the start bit and becomes byte bit 7.
- R4: In the control byte, bit 7 is the start bit and bits 6:4 are the select code {sel2,sel1,sel0}. Bit 3 is the mode bit (1 = single-ended, 0 = differential). Bits 2:0 have no effect.
- R5: In single-ended mode the positive channel index is {sel1,sel0,sel2}. com_neg_o is 1 and no negative channel enable is set.
- R6: In differential mode (8 channels) the positive index is {sel2,sel1,sel0} and the negative index is that value with bit 0 inverted. com_neg_o is 0.
- R7: In the 4-channel variant the single-ended index is {sel0,sel2}. The differential positive index is {sel2,sel0} and its partner is the index with bit 0 inverted.
- R8: In the 4-channel variant a byte with sel1 = 1 gives a one-cycle cfg_err_o pulse. It gives no conversion request and leaves the enables unchanged.
- R9: Each accepted byte gives exactly one conv_req_o pulse one clock wide. The enables change only in the cycle of that pulse.
- R10: Raising chip select in the middle of a byte discards the partial capture and rearms start-bit detection.
- R11: The status strobe drops in the cycle after a request. It returns high CONV_CYCLES clocks later.
- R12: Data-out is 0 while chip select is high and before the first result exists. A result is {select code, mode bit, 10-bit count of requests since reset} and is sent MSB first. The MSB is present once the strobe is high, and each falling serial-clock edge with chip select low moves to the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| strobe_o | output | 1 | Status strobe, low while converting |
| conv_req_o | output | 1 | Conversion request pulse |
| cfg_err_o | output | 1 | Invalid select code pulse |
| pos_en_o | output | NUM_CH | Positive input enable, one-hot |
| neg_en_o | output | NUM_CH | Negative input enable, one-hot |
| com_neg_o | output | 1 | Common line used as negative input |

## Verification
If the capture state is wrong, the effect shows within one byte time. A missed start bit or a stale bit count moves the byte by one position, so the enables and the next conversion request are wrong, or a request goes missing, as soon as the eighth rising edge is expected. A wrong decode shows as soon as the request pulse occurs, because the enables are compared against independently computed channel masks in the cycle of that pulse. A wrong busy timer or result register shows after CONV_CYCLES clocks, either as a strobe level at the wrong time or as a wrong bit during the fourteen-bit readout.

// File: rtl/ctl_byte_rx_pkg.sv
package ctl_byte_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int TAG_W  = SEL_W + 1;

  typedef struct packed {
    logic             start;
    logic [SEL_W-1:0] sel;     // {sel2,sel1,sel0}
    logic             single;
    logic [2:0]       spare;
  } ctl_byte_t;

  typedef enum logic {ST_HUNT, ST_LOAD} cap_st_e;
endpackage

// File: rtl/ctl_byte_rx_sync.sv
module ctl_byte_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= RST_VAL;
      else if (i == 0) pipe_q[i] <= d_i;
      else pipe_q[i] <= pipe_q[(i > 0) ? i - 1 : 0];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ctl_byte_rx_shift.sv
module ctl_byte_rx_shift
  import ctl_byte_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_i,
  input  logic      rise_i,
  input  logic      din_i,
  output logic      vld_o,
  output ctl_byte_t byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  cap_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] byte_q;
  logic              vld_q;
  logic [BYTE_W-1:0] sr_nx;

  assign sr_nx = {sr_q[BYTE_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      sr_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (cs_i) begin
        st_q  <= ST_HUNT;   // abort partial capture
        cnt_q <= '0;
      end else if (rise_i) begin
        if (st_q == ST_HUNT) begin
          if (din_i) begin
            st_q  <= ST_LOAD;
            sr_q  <= BYTE_W'(1);
            cnt_q <= CNT_W'(1);
          end
        end else begin
          sr_q <= sr_nx;
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            vld_q  <= 1'b1;
            byte_q <= sr_nx;
            st_q   <= ST_HUNT;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign vld_o  = vld_q;
  assign byte_o = ctl_byte_t'(byte_q);
endmodule

// File: rtl/ctl_byte_rx_decode.sv
module ctl_byte_rx_decode
  import ctl_byte_rx_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              single_i,
  output logic              conv_req_o,
  output logic              cfg_err_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [NUM_CH-1:0] pos_en_o,
  output logic [NUM_CH-1:0] neg_en_o,
  output logic              com_neg_o
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [IDX_W-1:0]  se_idx, df_idx;
  logic              code_ok;
  logic [NUM_CH-1:0] pos_nx, neg_nx;

  if (NUM_CH == 8) begin : g_ch8
    assign se_idx  = {sel_i[1], sel_i[0], sel_i[2]};
    assign df_idx  = sel_i;
    assign code_ok = 1'b1;
  end else begin : g_ch4
    logic unused_sel;
    assign unused_sel = sel_i[1];
    assign se_idx  = {sel_i[0], sel_i[2]};
    assign df_idx  = {sel_i[2], sel_i[0]};
    assign code_ok = !sel_i[1];
  end

  always_comb begin
    pos_nx = '0;
    neg_nx = '0;
    if (single_i) begin
      pos_nx[se_idx] = 1'b1;
    end else begin
      pos_nx[df_idx] = 1'b1;
      neg_nx[{df_idx[IDX_W-1:1], ~df_idx[0]}] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_req_o <= 1'b0;
      cfg_err_o  <= 1'b0;
      tag_o      <= '0;
      pos_en_o   <= '0;
      neg_en_o   <= '0;
      com_neg_o  <= 1'b0;
    end else begin
      conv_req_o <= 1'b0;
      cfg_err_o  <= 1'b0;
      if (vld_i) begin
        if (code_ok) begin
          conv_req_o <= 1'b1;
          tag_o      <= {sel_i, single_i};
          pos_en_o   <= pos_nx;
          neg_en_o   <= neg_nx;
          com_neg_o  <= single_i;
        end else begin
          cfg_err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_byte_rx_conv.sv
module ctl_byte_rx_conv
  import ctl_byte_rx_pkg::*;
#(
  parameter int CONV_CYCLES = 40,
  parameter int RES_W       = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             cs_i,
  input  logic             fall_i,
  output logic             strobe_o,
  output logic             dout_o
);
  localparam int TMR_W = $clog2(CONV_CYCLES);
  localparam int CNT_W = RES_W - TAG_W;

  logic             busy_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      cnt_q  <= '0;
      tag_q  <= '0;
      res_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tmr_q  <= TMR_W'(CONV_CYCLES - 1);
      cnt_q  <= cnt_q + 1'b1;
      tag_q  <= tag_i;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_q <= 1'b0;
        res_q  <= {tag_q, cnt_q};
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else if (fall_i && !cs_i) begin
      res_q <= {res_q[RES_W-2:0], 1'b0};
    end
  end

  assign strobe_o = !busy_q;
  assign dout_o   = !cs_i && res_q[RES_W-1];
endmodule

// File: rtl/ctl_byte_rx.sv
module ctl_byte_rx
  import ctl_byte_rx_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 40,
  parameter int RES_W       = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              strobe_o,
  output logic              conv_req_o,
  output logic              cfg_err_o,
  output logic [NUM_CH-1:0] pos_en_o,
  output logic [NUM_CH-1:0] neg_en_o,
  output logic              com_neg_o
);
  logic             cs_s, sclk_s, din_s, sclk_q;
  logic             rise, fall, byte_vld;
  ctl_byte_t        ctl;
  logic [TAG_W-1:0] tag;
  logic             unused_bits;

  ctl_byte_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s));
  ctl_byte_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  ctl_byte_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk_i, .rst_ni, .d_i(din_i), .q_o(din_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end

  assign rise = sclk_s && !sclk_q;
  assign fall = !sclk_s && sclk_q;

  ctl_byte_rx_shift u_shift (
    .clk_i, .rst_ni, .cs_i(cs_s), .rise_i(rise), .din_i(din_s),
    .vld_o(byte_vld), .byte_o(ctl));

  assign unused_bits = ^{ctl.start, ctl.spare};

  ctl_byte_rx_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk_i, .rst_ni, .vld_i(byte_vld), .sel_i(ctl.sel), .single_i(ctl.single),
    .conv_req_o, .cfg_err_o, .tag_o(tag), .pos_en_o, .neg_en_o, .com_neg_o);

  ctl_byte_rx_conv #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_conv (
    .clk_i, .rst_ni, .start_i(conv_req_o), .tag_i(tag), .cs_i(cs_s),
    .fall_i(fall), .strobe_o, .dout_o);
endmodule

// File: rtl/ctl_byte_rx_chk.sv
module ctl_byte_rx_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_o,
  input logic              conv_req_o,
  input logic              cfg_err_o,
  input logic [NUM_CH-1:0] pos_en_o,
  input logic [NUM_CH-1:0] neg_en_o,
  input logic              com_neg_o
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o); // R9
  AST_POS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pos_en_o)); // R5
  AST_NEG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(neg_en_o)); // R6
  AST_EN_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_en_o & neg_en_o) == '0); // R6
  AST_COM_NO_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_neg_o |-> (neg_en_o == '0)); // R5
  AST_REQ_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_req_o && cfg_err_o)); // R8
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_en_o) |-> conv_req_o); // R9
  AST_NEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(neg_en_o) |-> conv_req_o); // R9
  AST_STROBE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !strobe_o); // R11
endmodule

bind ctl_byte_rx ctl_byte_rx_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(strobe_o), .conv_req_o(conv_req_o),
  .cfg_err_o(cfg_err_o), .pos_en_o(pos_en_o), .neg_en_o(neg_en_o),
  .com_neg_o(com_neg_o));

// File: tb/ctl_byte_rx_bench.sv
module ctl_byte_rx_bench;
  localparam int H    = 6;
  localparam int CONV = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout8, strobe8, req8, err8, com8;
  logic dout4, strobe4, req4, err4, com4;
  logic [7:0] pos8, neg8;
  logic [3:0] pos4, neg4;

  int n_cmp = 0, n_bad = 0;
  int req8_n = 0, err8_n = 0, req4_n = 0, err4_n = 0;
  int cnt8 = 0;
  logic [7:0] e_pos8 = '0, e_neg8 = '0, e_pos4 = '0, e_neg4 = '0;
  logic e_com8 = 1'b0, e_com4 = 1'b0;

  always #2 clk = ~clk;

  ctl_byte_rx #(.NUM_CH(8), .CONV_CYCLES(CONV)) u_ctl_byte_rx (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout8), .strobe_o(strobe8), .conv_req_o(req8), .cfg_err_o(err8),
    .pos_en_o(pos8), .neg_en_o(neg8), .com_neg_o(com8));

  ctl_byte_rx #(.NUM_CH(4), .CONV_CYCLES(CONV)) u_ctl_byte_rx_n4 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout4), .strobe_o(strobe4), .conv_req_o(req4), .cfg_err_o(err4),
    .pos_en_o(pos4), .neg_en_o(neg4), .com_neg_o(com4));

  always @(negedge clk) begin
    if (req8) req8_n++;
    if (err8) err8_n++;
    if (req4) req4_n++;
    if (err4) err4_n++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] mask_of(input logic [7:0] b, input int nch, input bit neg);
    logic s2, s1, s0;
    int idx;
    s2 = b[6]; s1 = b[5]; s0 = b[4];
    if (b[3]) begin
      if (neg) return 8'h0;
      idx = (nch == 8) ? {s1, s0, s2} : {s0, s2};
    end else begin
      idx = (nch == 8) ? {s2, s1, s0} : {s2, s0};
      if (neg) idx = idx ^ 1;
    end
    return 8'(1 << idx);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    din = b;  wait_clk(H);
    sclk = 1; wait_clk(H);
    sclk = 0; wait_clk(H);
  endtask

  // send one framed byte, check enables and pulses, optionally read result
  task automatic do_byte(input logic [7:0] b, input int zeros, input bit readout);
    int r8, e8, r4, e4;
    logic [13:0] res;
    r8 = req8_n; e8 = err8_n; r4 = req4_n; e4 = err4_n;
    cs_n = 0; wait_clk(H);
    for (int i = 0; i < zeros; i++) send_bit(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    e_pos8 = mask_of(b, 8, 0); e_neg8 = mask_of(b, 8, 1); e_com8 = b[3];
    cnt8++;
    if (!b[5]) begin
      e_pos4 = mask_of(b, 4, 0); e_neg4 = mask_of(b, 4, 1); e_com4 = b[3];
    end
    check("R3 R9 req8", req8_n - r8, 1);
    check("R8 err8", err8_n - e8, 0);
    check("R5 R6 R4 pos8", pos8, e_pos8);
    check("R5 R6 R4 neg8", neg8, e_neg8);
    check("R5 com8", com8, e_com8);
    check("R8 R9 req4", req4_n - r4, b[5] ? 0 : 1);
    check("R8 err4", err4_n - e4, b[5] ? 1 : 0);
    check("R7 R8 pos4", pos4, e_pos4[3:0]);
    check("R7 R8 neg4", neg4, e_neg4[3:0]);
    check("R7 com4", com4, e_com4);
    check("R11 strobe busy", strobe8, 0);
    wait_clk(CONV + 8);
    check("R11 strobe done", strobe8, 1);
    if (readout) begin
      res = {b[6:3], 10'(cnt8)};
      for (int k = 0; k < 14; k++) begin
        check("R12 dout bit", dout8, res[13-k]);
        send_bit(1'b0);
      end
      check("R12 dout drained", dout8, 0);
    end
    cs_n = 1; wait_clk(2 * H);
    check("R12 dout cs high", dout8, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int r0;
    logic [7:0] b;
    void'($urandom(32'h5eed_1234));
    wait_clk(5);
    rst_n = 1;
    wait_clk(4);
    // R1 reset state
    check("R1 strobe", strobe8, 1);
    check("R1 dout", dout8, 0);
    check("R1 pos", pos8, 0);
    check("R1 neg", neg8, 0);
    check("R1 com", com8, 0);
    check("R1 pos4", pos4, 0);

    // R2 edges with cs high capture nothing
    r0 = req8_n;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    check("R2 no capture cs high", req8_n - r0, 0);

    // R12 zeros before any result
    cs_n = 0; wait_clk(H);
    for (int i = 0; i < 6; i++) begin
      check("R12 dout before result", dout8, 0);
      send_bit(1'b0);
    end
    cs_n = 1; wait_clk(2 * H);

    // R10 abort partial capture, then full byte
    r0 = req8_n;
    cs_n = 0; wait_clk(H);
    send_bit(1); send_bit(0); send_bit(1);
    cs_n = 1; wait_clk(2 * H);
    check("R10 no req after abort", req8_n - r0, 0);
    do_byte(8'b1001_1000, 0, 1);

    // R4 spare bits have no effect; R5/R6/R7 directed codes
    do_byte(8'b1001_1111, 2, 0);
    do_byte(8'b1100_0000, 5, 1);
    do_byte(8'b1110_0101, 1, 0);   // 4-ch invalid
    do_byte(8'b1000_0000, 0, 0);
    do_byte(8'b1111_1000, 3, 1);

    // constrained random
    for (int t = 0; t < 30; t++) begin
      b = 8'($urandom) | 8'h80;
      if ($urandom_range(0, 4) == 0) begin
        r0 = req8_n;
        cs_n = 0; wait_clk(H);
        for (int i = 0; i < int'($urandom_range(1, 6)); i++) send_bit(1'($urandom));
        cs_n = 1; wait_clk(2 * H);
        check("R10 random abort", req8_n - r0, 0);
      end
      do_byte(b, $urandom_range(0, 4), t % 3 == 0);
    end
    summary();
  end
endmodule